// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Sign-Injection Unit

This unit evaluates one of eight binary32 operations on two operands and returns a 32-bit result, a five-bit exception flag vector and a one-cycle completion strobe. The operations are equality, less-than, less-or-equal, minimum, maximum, and three sign-injection forms. A caller places an operation code and operands `a` and `b` on the inputs and raises `start` for one cycle. It then waits for `done`. Result and flags stay on the outputs until the next operation completes.

The operation groups differ in how they treat subnormals and in how long they take. The three comparisons treat a subnormal input as a zero of the same sign, and they finish after one clock edge. Minimum and maximum compare operands at their exact value and pass them through bit for bit, and they finish after two edges. Sign injection rewrites only the sign bit, so subnormals pass through unchanged, and it finishes after one edge. The unit only produces flag bits. Accumulating them into a status register is up to the caller.

Top module: `fp_cmp_sign_unit`

## Requirements
- R1: Operation codes are 0 equal, 1 less-than, 2 less-or-equal, 3 minimum, 4 maximum, 5 sign copy, 6 sign negate, 7 sign xor. A comparison accepted at clock edge k raises `done` in the cycle after edge k. Its boolean answer is in result bit 0, and result bits 31:1 are 0.
- R2: A comparison with no NaN operand returns 1 when the relation between `a` and `b` holds and 0 otherwise. +0 and -0 compare equal.
- R3: Before it compares, a comparison replaces any subnormal input (exponent field 0, fraction nonzero) with a zero of the same sign.
- R4: Flags bit 4 is the invalid flag, and flags bits 3:0 are always 0. A comparison with any NaN operand returns 0. Equality sets invalid only for a signaling NaN (fraction bit 22 clear). Less-than and less-or-equal set invalid for any NaN.
- R5: Minimum returns `a` when a<b and `b` otherwise. Maximum returns `b` when a<b and `a` otherwise. Here -0 orders below +0. `done` rises in the cycle after the second edge following acceptance.
- R6: Minimum and maximum compare subnormals at their exact value and return the chosen operand unchanged.
- R7: When one min/max operand is NaN, the other operand is returned. When both are NaN, 0x7FC00000 is returned. A signaling NaN on either operand sets invalid.
- R8: Sign injection finishes with the same timing as a comparison. It returns a's bits 30:0 with sign b[31] (code 5), ~b[31] (code 6) or a[31]^b[31] (code 7). Flags are 0 and subnormals are preserved.
- R9: `done` is high for exactly one cycle per accepted operation. A `start` raised while a min/max operation is in flight is ignored and produces no completion.
- R10: After reset, `done`, result and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe for one operation |
| op | input | 3 | Operation code |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| result | output | 32 | Result of the last completed operation |
| flags | output | 5 | Exception flags, bit 4 invalid |
| done | output | 1 | One-cycle completion strobe |

## Verification
The latency assertions assume that `start`, `op`, `a` and `b` are steady around the sampling edge. The bench drives every input on the falling edge, so this assumption always holds. The assertions also take `op` as sampled together with `start` to be the operation of record. The bench keeps `start` high for a single cycle per operation, except in one scenario that deliberately raises it again while a min/max operation is in flight.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int W      = 1 + EXP_W + MAN_W;
  localparam int FLAG_W = 5;
  localparam int NV_BIT = 4;
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [2:0] {
    OP_EQ = 3'd0, OP_LT = 3'd1, OP_LE = 3'd2, OP_MIN = 3'd3,
    OP_MAX = 3'd4, OP_SJ = 3'd5, OP_SJN = 3'd6, OP_SJX = 3'd7
  } fpcs_op_e;

  function automatic logic fp_is_nan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic fp_is_snan(input logic [W-1:0] x);
    return fp_is_nan(x) && !x[MAN_W-1];
  endfunction

  function automatic logic fp_is_zero(input logic [W-1:0] x);
    return x[W-2:0] == '0;
  endfunction

  function automatic logic [W-1:0] fp_flush(input logic [W-1:0] x);
    if (x[W-2:MAN_W] == '0) return {x[W-1], {(W-1){1'b0}}};
    return x;
  endfunction

  // Ordered less-than on non-NaN values; zeros_equal makes -0 == +0.
  function automatic logic fp_less(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic zeros_equal);
    logic r;
    if (zeros_equal && fp_is_zero(x) && fp_is_zero(y)) r = 1'b0;
    else if (x[W-1] != y[W-1])                         r = x[W-1];
    else if (x[W-1])                                   r = x[W-2:0] > y[W-2:0];
    else                                               r = x[W-2:0] < y[W-2:0];
    return r;
  endfunction

  function automatic logic op_is_cmp(input fpcs_op_e o);
    return (o == OP_EQ) || (o == OP_LT) || (o == OP_LE);
  endfunction

  function automatic logic op_is_mm(input fpcs_op_e o);
    return (o == OP_MIN) || (o == OP_MAX);
  endfunction
endpackage

// File: rtl/fpcs_compare.sv
module fpcs_compare
  import fpcs_pkg::*;
(
  input  fpcs_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           res_bit,
  output logic           nv
);
  logic [W-1:0] a_flushed, b_flushed;
  logic any_nan, any_snan, is_eq, is_lt;

  assign a_flushed = fp_flush(a);
  assign b_flushed = fp_flush(b);
  assign any_nan   = fp_is_nan(a) || fp_is_nan(b);
  assign any_snan  = fp_is_snan(a) || fp_is_snan(b);
  assign is_eq     = (a_flushed == b_flushed) ||
                     (fp_is_zero(a_flushed) && fp_is_zero(b_flushed));
  assign is_lt     = fp_less(a_flushed, b_flushed, 1'b1);

  always_comb begin
    res_bit = 1'b0;
    nv      = 1'b0;
    unique case (op)
      OP_EQ: begin res_bit = !any_nan && is_eq;           nv = any_snan; end
      OP_LT: begin res_bit = !any_nan && is_lt;           nv = any_nan;  end
      OP_LE: begin res_bit = !any_nan && (is_lt || is_eq); nv = any_nan; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpcs_minmax.sv
module fpcs_minmax
  import fpcs_pkg::*;
(
  input  logic           pick_max,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           nv
);
  logic a_nan, b_nan, a_below_b;

  assign a_nan     = fp_is_nan(a);
  assign b_nan     = fp_is_nan(b);
  assign a_below_b = fp_less(a, b, 1'b0);
  assign nv        = fp_is_snan(a) || fp_is_snan(b);

  always_comb begin
    if (a_nan && b_nan)  res = CANON_NAN;
    else if (a_nan)      res = b;
    else if (b_nan)      res = a;
    else if (pick_max)   res = a_below_b ? b : a;
    else                 res = a_below_b ? a : b;
  end
endmodule

// File: rtl/fpcs_sign.sv
module fpcs_sign
  import fpcs_pkg::*;
(
  input  fpcs_op_e       op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  logic new_sign;

  always_comb begin
    unique case (op)
      OP_SJN:  new_sign = ~b[W-1];
      OP_SJX:  new_sign = a[W-1] ^ b[W-1];
      default: new_sign = b[W-1];
    endcase
  end

  assign res = {new_sign, a[W-2:0]};
endmodule

// File: rtl/fp_cmp_sign_unit.sv
module fp_cmp_sign_unit
  import fpcs_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [31:0]  a,
  input  logic [31:0]  b,
  output logic [31:0]  result,
  output logic [4:0]   flags,
  output logic         done
);
  fpcs_op_e op_e;
  assign op_e = fpcs_op_e'(op);

  logic         cmp_bit, cmp_nv, mm_nv;
  logic [W-1:0] mm_res, sgn_res;

  fpcs_compare u_cmp (.op(op_e), .a(a), .b(b), .res_bit(cmp_bit), .nv(cmp_nv));
  fpcs_minmax  u_mm  (.pick_max(op_e == OP_MAX), .a(a), .b(b), .res(mm_res), .nv(mm_nv));
  fpcs_sign    u_sgn (.op(op_e), .a(a), .b(b), .res(sgn_res));

  // Named events for the checks.
  logic accept, accept_fast, accept_slow;
  logic busy_q, mm_nv_q, done_q;
  logic [W-1:0] mm_res_q, res_q;
  logic [FLAG_W-1:0] flags_q;
  fpcs_op_e op_q, mm_op_q;

  assign accept      = start && !busy_q;
  assign accept_slow = accept && op_is_mm(op_e);
  assign accept_fast = accept && !op_is_mm(op_e);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      mm_nv_q  <= 1'b0;
      mm_res_q <= '0;
      mm_op_q  <= OP_EQ;
      res_q    <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
      op_q     <= OP_EQ;
    end else begin
      done_q <= 1'b0;
      if (accept_fast) begin
        res_q   <= op_is_cmp(op_e) ? {{(W-1){1'b0}}, cmp_bit} : sgn_res;
        flags_q <= op_is_cmp(op_e) ? {cmp_nv, {(FLAG_W-1){1'b0}}} : '0;
        op_q    <= op_e;
        done_q  <= 1'b1;
      end
      if (accept_slow) begin
        busy_q   <= 1'b1;
        mm_res_q <= mm_res;
        mm_nv_q  <= mm_nv;
        mm_op_q  <= op_e;
      end
      if (busy_q) begin
        busy_q  <= 1'b0;
        res_q   <= mm_res_q;
        flags_q <= {mm_nv_q, {(FLAG_W-1){1'b0}}};
        op_q    <= mm_op_q;
        done_q  <= 1'b1;
      end
    end
  end

  assign result = res_q;
  assign flags  = flags_q;
  assign done   = done_q;

  // R1
  cmp_bit0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_is_cmp(op_q) |-> result[W-1:1] == '0);
  // R1
  fast_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q && !op_is_mm(op_e) |=> done);
  // R5
  slow_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q && op_is_mm(op_e) |=> !done ##1 done);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  // R9
  quiet_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done);
  // R4
  flag_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags[FLAG_W-2:0] == '0);
  // R8
  sign_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_is_cmp(op_q) && !op_is_mm(op_q) |-> flags == '0);
endmodule

// File: tb/fp_cmp_sign_unit_bench.sv
`timescale 1ns/1ps
module fp_cmp_sign_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] result;
  logic [4:0] flags;
  logic done;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_cmp_sign_unit u_fp_cmp_sign_unit (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .a(a), .b(b), .result(result), .flags(flags), .done(done));

  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000, MONE = 32'hBF800000,
    MTWO = 32'hC0000000, PZ = 32'h0, NZ = 32'h80000000, SUB1 = 32'h1, SUB2 = 32'h2,
    NSUB = 32'h80000005, QNAN = 32'h7FC00000, SNAN = 32'h7F800001, PINF = 32'h7F800000;

  function automatic bit m_nan(input logic [31:0] x);
    return ((x & 32'h7F800000) == 32'h7F800000) && ((x & 32'h007FFFFF) != 0);
  endfunction
  function automatic bit m_snan(input logic [31:0] x);
    return m_nan(x) && !x[22];
  endfunction
  // Monotonic integer key of a binary32 value.
  function automatic logic [31:0] m_key(input logic [31:0] x);
    return x[31] ? ~x : (x ^ 32'h80000000);
  endfunction
  function automatic logic [31:0] m_ftz(input logic [31:0] x);
    logic [31:0] y;
    y = ((x & 32'h7F800000) == 0) ? (x & 32'h80000000) : x;
    if ((y & 32'h7FFFFFFF) == 0) y = 0;
    return y;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output logic [4:0] f, output int lat);
    logic [31:0] kx, ky;
    bit nan;
    r = 0; f = 0; lat = 1;
    nan = m_nan(x) || m_nan(y);
    kx = m_key(m_ftz(x)); ky = m_key(m_ftz(y));
    case (o)
      3'd0: begin r = {31'b0, !nan && kx == ky}; f[4] = m_snan(x) || m_snan(y); end
      3'd1: begin r = {31'b0, !nan && kx < ky};  f[4] = nan; end
      3'd2: begin r = {31'b0, !nan && kx <= ky}; f[4] = nan; end
      3'd3, 3'd4: begin
        lat = 2;
        f[4] = m_snan(x) || m_snan(y);
        if (m_nan(x) && m_nan(y)) r = 32'h7FC00000;
        else if (m_nan(x)) r = y;
        else if (m_nan(y)) r = x;
        else if (o == 3'd3) r = (m_key(x) < m_key(y)) ? x : y;
        else r = (m_key(x) < m_key(y)) ? y : x;
      end
      3'd5: r = {y[31], x[30:0]};
      3'd6: r = {!y[31], x[30:0]};
      default: r = {x[31] ^ y[31], x[30:0]};
    endcase
  endtask

  task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] x,
                        input logic [31:0] y);
    logic [31:0] er; logic [4:0] ef; int el; int n; bit got;
    model(o, x, y, er, ef, el);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    n = 0; got = 0;
    while (n < 6 && !got) begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (done) got = 1;
    end
    chk(req, "latency", got ? n : 99, el);
    chk(req, "result", result, er);
    chk(req, "flags", {27'b0, flags}, {27'b0, ef});
  endtask

  task automatic t_reset;
    chk("R10", "done", {31'b0, done}, 0);
    chk("R10", "result", result, 0);
    chk("R10", "flags", {27'b0, flags}, 0);
  endtask

  task automatic t_compare;
    run_op("R1", 3'd1, ONE, TWO);
    run_op("R2", 3'd2, TWO, TWO);
    run_op("R2", 3'd0, ONE, MONE);
    run_op("R2", 3'd1, MONE, ONE);
    run_op("R2", 3'd1, TWO, ONE);
    run_op("R2", 3'd0, PZ, NZ);
    run_op("R2", 3'd1, NZ, PZ);
    run_op("R2", 3'd2, MTWO, MONE);
    run_op("R2", 3'd1, ONE, PINF);
  endtask

  task automatic t_flush;
    run_op("R3", 3'd0, SUB1, SUB2);
    run_op("R3", 3'd1, SUB1, SUB2);
    run_op("R3", 3'd0, NSUB, PZ);
    run_op("R3", 3'd2, SUB2, NZ);
  endtask

  task automatic t_cmp_nan;
    run_op("R4", 3'd0, QNAN, ONE);
    run_op("R4", 3'd0, SNAN, ONE);
    run_op("R4", 3'd1, QNAN, ONE);
    run_op("R4", 3'd2, ONE, SNAN);
  endtask

  task automatic t_minmax;
    run_op("R5", 3'd3, ONE, TWO);
    run_op("R5", 3'd4, ONE, TWO);
    run_op("R5", 3'd3, PZ, NZ);
    run_op("R5", 3'd4, NZ, PZ);
    run_op("R5", 3'd3, MONE, MTWO);
    run_op("R6", 3'd3, SUB2, SUB1);
    run_op("R6", 3'd4, SUB1, SUB2);
    run_op("R6", 3'd3, NSUB, SUB1);
  endtask

  task automatic t_mm_nan;
    run_op("R7", 3'd3, QNAN, TWO);
    run_op("R7", 3'd4, ONE, SNAN);
    run_op("R7", 3'd3, QNAN, SNAN);
  endtask

  task automatic t_sign;
    run_op("R8", 3'd5, ONE, MTWO);
    run_op("R8", 3'd6, ONE, ONE);
    run_op("R8", 3'd7, MONE, MONE);
    run_op("R8", 3'd6, NSUB, NSUB);
    run_op("R8", 3'd7, SUB1, MONE);
  endtask

  // R9: a second start while a maximum is in flight must be dropped.
  task automatic t_busy;
    @(negedge clk);
    start = 1'b1; op = 3'd4; a = ONE; b = TWO;
    @(negedge clk);
    chk("R9", "no early done", {31'b0, done}, 0);
    op = 3'd1; a = TWO; b = ONE;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done", {31'b0, done}, 1);
    chk("R9", "max result kept", result, TWO);
    @(negedge clk);
    chk("R9", "ignored start silent", {31'b0, done}, 0);
    chk("R9", "result unchanged", result, TWO);
    @(negedge clk);
    chk("R9", "still silent", {31'b0, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_flush();
    t_cmp_nan();
    t_minmax();
    t_mm_nan();
    t_sign();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule